// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps the time of day and the calendar date as seven packed-BCD fields: seconds, minutes, hours (24-hour form), a one-hot weekday, day of month, month, and a two-digit year. A free-running enable, `base_en`, feeds an internal prescaler. Every `PRESCALE_DIV` enables the prescaler produces one second, and each second advances the chain of fields. Carries run from seconds to minutes, then hours, then the day. The day carry moves both the day of month and the weekday, and it can go on into the month and the year.

Software loads any field through a single-cycle write port, selected by a 3-bit code. Every field is always visible on its own read output, with the bits the field does not use forced to zero. A level input, `halt`, freezes all counting while it is high. Writes still land while the block is halted. The block drives one-cycle `second_tick` and `minute_tick` pulses on the seconds and minutes rollovers, so that interrupt logic outside the block can use them.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read 00:00:00, weekday 8'h01, day of month 8'h01, month 8'h01 and year 8'h01. Both tick outputs are low.
- R2: The seconds field counts up in BCD once per `PRESCALE_DIV` cycles of `base_en`. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours. Hours 23 wraps to 00 and produces the day carry.
- R3: On a day carry the day of month advances and wraps to 01 after the last day of the month. April, June, September and November have 30 days; the other months except February have 31. A wrap of the day of month advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R4: February has 29 days when the two-digit year is a multiple of 4 (00 included) and 28 days otherwise.
- R5: On each day carry the weekday bit moves one place toward the MSB. Bit 6 wraps back to bit 0.
- R6: `wr_sel` picks the field to write: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year. Code 7 changes no field. Bits that a field does not use read as zero whatever was written. Seconds and minutes use bits 6:0, hours and day of month use bits 5:0, month uses bits 4:0, weekday uses bits 6:0, and year uses all 8 bits.
- R7: A write appears on the read outputs in the cycle after it is presented. A write also restarts the prescaler, so the next seconds step comes exactly `PRESCALE_DIV` enables after the write.
- R8: While `halt` is high no field changes except by a write, no tick pulse is produced, and the prescaler phase is held.
- R9: `second_tick` is high for exactly one cycle, in the cycle the read outputs first show the seconds wrap 59→00. `minute_tick` does the same for the minutes wrap and is never high without `second_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | Prescaler input enable; `PRESCALE_DIV` of these make one second |
| halt | input | 1 | High freezes all counting |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 3 | Field select code for the write |
| wr_data | input | 8 | BCD value to write |
| rd_sec | output | 8 | Seconds, BCD |
| rd_min | output | 8 | Minutes, BCD |
| rd_hour | output | 8 | Hours, BCD, 24-hour form |
| rd_wday | output | 8 | Weekday, one-hot in bits 6:0 |
| rd_date | output | 8 | Day of month, BCD |
| rd_month | output | 8 | Month, BCD |
| rd_year | output | 8 | Two-digit year, BCD |
| second_tick | output | 1 | One-cycle pulse on the seconds wrap |
| minute_tick | output | 1 | One-cycle pulse on the minutes wrap |

## Verification
The bench goes after the month-end boundaries: 30- and 31-day months, February 28 in a year that is not a multiple of 4, February 28 and 29 in years 24 and 00, and the year-end cascade from 23:59:59 on 31/12/99 with the weekday on bit 6. A wrong month-length or leap decode would skip a day or produce a 30th or 32nd of the month. A broken cascade would leave a field stale or fail to wrap the weekday back to bit 0.

The bench also writes a field part-way through a second and checks that the next step comes a full second after the write. A design that kept the old prescaler phase would step early. It writes values that carry stray bits in the unused positions, and a write with code 7; an unmasked design would show those bits, and a loose decoder would corrupt a field. The last targets are a write while halted and the one-cycle width of the tick pulses. A design that let the halt leak would advance, and one that held the ticks would flag more than one interrupt.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int unsigned FIELD_W = 8;
   localparam int unsigned NUM_FIELDS = 7;

   localparam int IX_SEC   = 0;
   localparam int IX_MIN   = 1;
   localparam int IX_HOUR  = 2;
   localparam int IX_WDAY  = 3;
   localparam int IX_DATE  = 4;
   localparam int IX_MONTH = 5;
   localparam int IX_YEAR  = 6;

   localparam logic [FIELD_W-1:0] MASK_SEC   = 8'h7F;
   localparam logic [FIELD_W-1:0] MASK_MIN   = 8'h7F;
   localparam logic [FIELD_W-1:0] MASK_HOUR  = 8'h3F;
   localparam logic [FIELD_W-1:0] MASK_WDAY  = 8'h7F;
   localparam logic [FIELD_W-1:0] MASK_DATE  = 8'h3F;
   localparam logic [FIELD_W-1:0] MASK_MONTH = 8'h1F;
   localparam logic [FIELD_W-1:0] MASK_YEAR  = 8'hFF;

   // Next value of a two-digit BCD number (no wrap at the top).
   function automatic logic [FIELD_W-1:0] bcd_next(input logic [FIELD_W-1:0] v);
      logic [FIELD_W-1:0] r;
      if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
      else                r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // Two-digit BCD year is a multiple of 4: 10*t + u = 2*t + u (mod 4).
   function automatic logic year_is_leap(input logic [FIELD_W-1:0] y);
      logic [4:0] s;
      s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   // Last day of the month, in BCD.
   function automatic logic [FIELD_W-1:0] month_last(input logic [FIELD_W-1:0] m,
                                                     input logic [FIELD_W-1:0] y);
      logic [FIELD_W-1:0] r;
      case (m)
         8'h02:                      r = year_is_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic base_en,
   input  logic run,
   input  logic restart,
   output logic sec_pulse
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("rtc_prescaler: DIV must be at least 2");
      end
   endgenerate

   logic [PW-1:0] phase_q;

   assign sec_pulse = base_en && run && !restart && (phase_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart) begin
         phase_q <= '0;
      end else if (base_en && run) begin
         phase_q <= sec_pulse ? '0 : phase_q + PW'(1);
      end
   end

   // R7
   restart_blocks_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !sec_pulse);

   // R2
   pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> !sec_pulse);

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_pkg::*;
#(
   parameter logic [FIELD_W-1:0] MASK  = 8'h7F,
   parameter logic [FIELD_W-1:0] FLOOR = 8'h00,
   parameter logic [FIELD_W-1:0] RST   = 8'h00
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [FIELD_W-1:0] wr_val,
   input  logic               inc,
   input  logic [FIELD_W-1:0] ceil,
   output logic [FIELD_W-1:0] q,
   output logic               wrap
);
   generate
      if ((FLOOR & ~MASK) != '0 || (RST & ~MASK) != '0) begin : g_bad_cfg
         $error("rtc_bcd_field: floor or reset value outside the field mask");
      end
   endgenerate

   // >= also recovers from a written value past the ceiling
   assign wrap = inc && (q >= ceil);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= RST;
      end else if (wr) begin
         q <= wr_val & MASK;
      end else if (inc) begin
         q <= wrap ? FLOOR : (bcd_next(q) & MASK);
      end
   end

endmodule

// File: rtl/rtc_weekday.sv
module rtc_weekday
   import rtc_pkg::*;
#(
   parameter logic [FIELD_W-1:0] RST = 8'h01
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [FIELD_W-1:0] wr_val,
   input  logic               inc,
   output logic [FIELD_W-1:0] q,
   output logic               wrap
);
   generate
      if (RST[7] != 1'b0) begin : g_bad_rst
         $error("rtc_weekday: reset value uses bit 7");
      end
   endgenerate

   assign wrap = inc && q[6];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= RST;
      end else if (wr) begin
         q <= wr_val & MASK_WDAY;
      end else if (inc) begin
         q <= {1'b0, q[5:0], q[6]};
      end
   end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_pkg::*;
#(
   parameter int unsigned PRESCALE_DIV = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       base_en,
   input  logic       halt,
   input  logic       wr_en,
   input  logic [2:0] wr_sel,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_sec,
   output logic [7:0] rd_min,
   output logic [7:0] rd_hour,
   output logic [7:0] rd_wday,
   output logic [7:0] rd_date,
   output logic [7:0] rd_month,
   output logic [7:0] rd_year,
   output logic       second_tick,
   output logic       minute_tick
);
   localparam int unsigned NF = NUM_FIELDS;
   localparam int unsigned W  = FIELD_W;

   // Per-field constants, field i in slice [i*W +: W]
   localparam logic [NF*W-1:0] FMASK_V  = {MASK_YEAR, MASK_MONTH, MASK_DATE, MASK_WDAY,
                                           MASK_HOUR, MASK_MIN, MASK_SEC};
   localparam logic [NF*W-1:0] FCEIL_V  = {8'h99, 8'h12, 8'h31, 8'h00, 8'h23, 8'h59, 8'h59};
   localparam logic [NF*W-1:0] FFLOOR_V = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
   localparam logic [NF*W-1:0] FRST_V   = {8'h01, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

   generate
      if (PRESCALE_DIV < 2) begin : g_bad_div
         $error("bcd_rtc_core: PRESCALE_DIV must be at least 2");
      end
      if (W != 8) begin : g_bad_w
         $error("bcd_rtc_core: fields are two BCD digits wide");
      end
   endgenerate

   logic                 sec_pulse;
   logic [NF-1:0]        inc_v;
   logic [NF-1:0]        wrap_v;
   logic [NF-1:0]        wr_hit;
   logic [NF-1:0][W-1:0] q_v;
   logic [W-1:0]         date_ceil;

   rtc_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_en  (base_en),
      .run      (!halt),
      .restart  (wr_en),
      .sec_pulse(sec_pulse)
   );

   // Carry chain: the hour wrap feeds both weekday and day of month
   assign inc_v[IX_SEC]   = sec_pulse;
   assign inc_v[IX_MIN]   = wrap_v[IX_SEC];
   assign inc_v[IX_HOUR]  = wrap_v[IX_MIN];
   assign inc_v[IX_WDAY]  = wrap_v[IX_HOUR];
   assign inc_v[IX_DATE]  = wrap_v[IX_HOUR];
   assign inc_v[IX_MONTH] = wrap_v[IX_DATE];
   assign inc_v[IX_YEAR]  = wrap_v[IX_MONTH];

   assign date_ceil = month_last(q_v[IX_MONTH], q_v[IX_YEAR]);

   generate
      for (genvar i = 0; i < NF; i++) begin : g_fld
         assign wr_hit[i] = wr_en && (wr_sel == 3'(i));
         if (i == IX_WDAY) begin : g_wday
            rtc_weekday #(.RST(FRST_V[i*W +: W])) u_wday (
               .clk   (clk),
               .rst_n (rst_n),
               .wr    (wr_hit[i]),
               .wr_val(wr_data),
               .inc   (inc_v[i]),
               .q     (q_v[i]),
               .wrap  (wrap_v[i])
            );
         end else begin : g_bcd
            logic [W-1:0] ceil_i;
            if (i == IX_DATE) begin : g_dyn
               assign ceil_i = date_ceil;
            end else begin : g_fix
               assign ceil_i = FCEIL_V[i*W +: W];
            end
            rtc_bcd_field #(
               .MASK (FMASK_V[i*W +: W]),
               .FLOOR(FFLOOR_V[i*W +: W]),
               .RST  (FRST_V[i*W +: W])
            ) u_cnt (
               .clk   (clk),
               .rst_n (rst_n),
               .wr    (wr_hit[i]),
               .wr_val(wr_data),
               .inc   (inc_v[i]),
               .ceil  (ceil_i),
               .q     (q_v[i]),
               .wrap  (wrap_v[i])
            );
         end
      end
   endgenerate

   assign rd_sec   = q_v[IX_SEC];
   assign rd_min   = q_v[IX_MIN];
   assign rd_hour  = q_v[IX_HOUR];
   assign rd_wday  = q_v[IX_WDAY];
   assign rd_date  = q_v[IX_DATE];
   assign rd_month = q_v[IX_MONTH];
   assign rd_year  = q_v[IX_YEAR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         second_tick <= 1'b0;
         minute_tick <= 1'b0;
      end else begin
         second_tick <= wrap_v[IX_SEC];
         minute_tick <= wrap_v[IX_MIN];
      end
   end

   // R8
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !wr_en) |=> ($stable(rd_sec) && $stable(rd_min) && $stable(rd_hour) &&
                            $stable(rd_wday) && $stable(rd_date) && $stable(rd_month) &&
                            $stable(rd_year) && !second_tick));

   // R9
   minute_needs_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      minute_tick |-> second_tick);

   // R9
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      second_tick |=> !second_tick);

   // R2
   sec_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      second_tick |-> (rd_sec == 8'h00));

   // R3
   year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_v[IX_YEAR] |=> (rd_year == 8'h00));

   // R5
   wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_v[IX_WDAY] |=> (rd_wday == 8'h01));

endmodule

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
   localparam int unsigned DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       base_en = 1'b1;
   logic       halt = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_sec, rd_min, rd_hour, rd_wday, rd_date, rd_month, rd_year;
   logic       second_tick, minute_tick;

   always #4 clk = ~clk;

   bcd_rtc_core #(.PRESCALE_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .base_en(base_en), .halt(halt),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_wday(rd_wday),
      .rd_date(rd_date), .rd_month(rd_month), .rd_year(rd_year),
      .second_tick(second_tick), .minute_tick(minute_tick)
   );

   typedef struct packed {
      logic [7:0] sec, min, hour, wday, date, month, year;
      logic st, mt;
   } snap_t;

   snap_t  cur;
   snap_t  exp_q[$];
   string  tag_q[$];
   int     n_chk = 0;
   int     n_fail = 0;
   bit     done = 1'b0;

   // Monitor: compares every queued expectation at the next falling edge
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         snap_t e, a;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = '{rd_sec, rd_min, rd_hour, rd_wday, rd_date, rd_month, rd_year,
               second_tick, minute_tick};
         n_chk++;
         if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, a, e);
         end
      end
   end

   task automatic push(input string t);
      exp_q.push_back(cur);
      tag_q.push_back(t);
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] h, m, s, wd, dt, mo, yr);
      wr(3'd2, h); wr(3'd1, m); wr(3'd3, wd); wr(3'd4, dt);
      wr(3'd5, mo); wr(3'd6, yr); wr(3'd0, s);
      cur = '{s, m, h, wd, dt, mo, yr, 1'b0, 1'b0};
   endtask

   // Expectation for the falling edge that follows the n-th second after the last write
   task automatic run_push(input int n, input string t);
      repeat (4 * n - 1) @(negedge clk);
      #1 push(t);
   endtask

   task automatic tick_clear(input string t);
      @(negedge clk);
      #1;
      cur.st = 1'b0; cur.mt = 1'b0;
      push(t);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 1'b0, 1'b0};
      #1 push("R1 reset state");

      // R2 plain seconds step
      set_time(8'h12, 8'h34, 8'h56, 8'h02, 8'h15, 8'h06, 8'h25);
      cur.sec = 8'h57;
      run_push(1, "R2 seconds step");

      // R2 R9 seconds wrap into minutes
      set_time(8'h12, 8'h34, 8'h59, 8'h02, 8'h15, 8'h06, 8'h25);
      cur.sec = 8'h00; cur.min = 8'h35; cur.st = 1'b1;
      run_push(1, "R9 seconds wrap");
      tick_clear("R9 second tick one cycle");

      // R2 R9 minute wrap into hours
      set_time(8'h12, 8'h59, 8'h59, 8'h02, 8'h15, 8'h06, 8'h25);
      cur.sec = 8'h00; cur.min = 8'h00; cur.hour = 8'h13; cur.st = 1'b1; cur.mt = 1'b1;
      run_push(1, "R2 minute wrap");
      tick_clear("R9 minute tick one cycle");

      // R3 R5 year-end cascade, weekday bit 6 wraps
      set_time(8'h23, 8'h59, 8'h59, 8'h40, 8'h31, 8'h12, 8'h99);
      cur = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 1'b1, 1'b1};
      run_push(1, "R3 year end cascade");

      // R4 R5 Feb 28 in year 24
      set_time(8'h23, 8'h59, 8'h59, 8'h04, 8'h28, 8'h02, 8'h24);
      cur = '{8'h00, 8'h00, 8'h00, 8'h08, 8'h29, 8'h02, 8'h24, 1'b1, 1'b1};
      run_push(1, "R4 leap Feb 28 to 29");

      // R4 Feb 29 in year 24
      set_time(8'h23, 8'h59, 8'h59, 8'h08, 8'h29, 8'h02, 8'h24);
      cur = '{8'h00, 8'h00, 8'h00, 8'h10, 8'h01, 8'h03, 8'h24, 1'b1, 1'b1};
      run_push(1, "R4 leap Feb 29 to Mar 1");

      // R4 Feb 28 in year 23
      set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
      cur = '{8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h23, 1'b1, 1'b1};
      run_push(1, "R4 common Feb 28 to Mar 1");

      // R4 year 00 is a leap year
      set_time(8'h23, 8'h59, 8'h59, 8'h20, 8'h28, 8'h02, 8'h00);
      cur = '{8'h00, 8'h00, 8'h00, 8'h40, 8'h29, 8'h02, 8'h00, 1'b1, 1'b1};
      run_push(1, "R4 year 00 leap");

      // R3 30-day month
      set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h30);
      cur = '{8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h05, 8'h30, 1'b1, 1'b1};
      run_push(1, "R3 April 30 end");

      // R3 31-day month does not end on 30
      set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h01, 8'h30);
      cur = '{8'h00, 8'h00, 8'h00, 8'h02, 8'h31, 8'h01, 8'h30, 1'b1, 1'b1};
      run_push(1, "R3 January 30 to 31");

      // R3 November 30
      set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h11, 8'h30);
      cur = '{8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h12, 8'h30, 1'b1, 1'b1};
      run_push(1, "R3 November 30 end");

      // R6 masking of unused bits, code 7 writes nothing
      set_time(8'h10, 8'h20, 8'h30, 8'h01, 8'h10, 8'h03, 8'h10);
      wr(3'd0, 8'hD9); cur.sec = 8'h59;   #1 push("R6 seconds mask");
      wr(3'd2, 8'hE3); cur.hour = 8'h23;  #1 push("R6 hours mask");
      wr(3'd3, 8'h81); cur.wday = 8'h01;  #1 push("R6 weekday mask");
      wr(3'd4, 8'hC5); cur.date = 8'h05;  #1 push("R6 date mask");
      wr(3'd5, 8'hF2); cur.month = 8'h12; #1 push("R6 month mask");
      wr(3'd7, 8'h45);                    #1 push("R6 code 7 ignored");

      // R7 write restarts the prescaler phase
      set_time(8'h08, 8'h00, 8'h10, 8'h01, 8'h10, 8'h03, 8'h10);
      @(negedge clk);
      wr(3'd0, 8'h20); cur.sec = 8'h20;
      repeat (2) @(negedge clk);
      #1 push("R7 no early step after write");
      @(negedge clk);
      #1 cur.sec = 8'h21; push("R7 step one second after write");

      // R8 halt freezes, writes still land, counting resumes
      set_time(8'h09, 8'h15, 8'h40, 8'h01, 8'h10, 8'h03, 8'h10);
      halt = 1'b1;
      repeat (11) @(negedge clk);
      #1 push("R8 frozen while halted");
      wr(3'd1, 8'h07); cur.min = 8'h07;
      #1 push("R8 write lands while halted");
      @(negedge clk);
      halt = 1'b0;
      cur.sec = 8'h41;
      run_push(1, "R8 resumes after halt");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule